// File: doc/BRIEF.md
# Shared-Memory Clock-Speed Arbiter

This block shares one DRAM between a CPU and a video scan engine, and it also sets how fast the CPU runs. A free-running master clock is split into CPU cycles. A normal CPU cycle is four master ticks long. The first half of the cycle belongs to video and the second half belongs to the CPU, so the two never contend for memory. The block drives a CPU clock enable that pulses on the last tick of each CPU cycle. The CPU is fully static, so a cycle may be stretched or shortened without any loss of state.

A 2-bit speed select picks one of three behaviours. **Normal** keeps every cycle at four ticks. **Partial** shortens a cycle to two ticks when the CPU's next access does not decode to RAM (for example ROM or I/O). That short cycle holds only the video half, because the CPU does not need memory during it. **Full** makes every cycle two ticks long and gives the CPU the memory on every tick. In full mode video simply scans out whatever the CPU is addressing, and controller refresh is switched off. Retention then depends on the CPU's own accesses.

During vertical blanking the video half-cycles are not needed for display. The block uses them to run a burst of DRAM refresh cycles, one row per cycle, taken from a row counter that wraps around.

Top module: `vidarb_clock_arbiter`

## Requirements
- R1: While reset is held, `cpuClkEn` and `refreshReq` are 0 and `memOwner` is video (0). The first cycle after reset is a normal four-tick cycle that starts at tick 0.
- R2: In normal mode (`speedSel` = 0) each cycle is four ticks. Ticks 0 and 1 give the memory to video, ticks 2 and 3 give it to the CPU, and `cpuClkEn` is high on tick 3 only.
- R3: In partial mode (`speedSel` = 1), a cycle whose `cpuIsRam` was 0 at its start is two ticks long, both ticks owned by video, with `cpuClkEn` high on the second tick. A cycle whose `cpuIsRam` was 1 behaves as in R2.
- R4: In full mode (`speedSel` = 2) every cycle is two ticks, the CPU owns the memory on both ticks, and `cpuClkEn` is high on the second tick. No two consecutive ticks both carry `cpuClkEn`.
- R5: `speedSel` and `cpuIsRam` are sampled only on the last tick of a cycle and govern the next cycle. Changes at any other tick have no effect on the cycle in progress.
- R6: The select value 3 behaves exactly like normal mode.
- R7: A rising edge of `vBlank` arms a burst of ROWS refreshes. While armed and `vBlank` is high, tick 0 of each cycle (outside full mode) becomes a refresh tick: `refreshReq` is 1 and `memOwner` is refresh (2). There is at most one refresh per cycle.
- R8: `refreshRow` advances by one after each refresh and wraps from ROWS-1 to 0. A burst that runs to completion touches every row exactly once.
- R9: Refresh is issued only while `vBlank` is high. If blanking ends before the burst completes, the rest of the burst is dropped, and the next rising edge re-arms a full burst.
- R10: While full mode governs the current cycle, no refresh is issued.
- R11: `memOwner` encodes video as 0, CPU as 1 and refresh as 2. Exactly one owner is driven on every tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| speedSel | input | 2 | Speed select: 0 normal, 1 partial, 2 full, 3 normal |
| cpuIsRam | input | 1 | The CPU's next access decodes to RAM |
| vBlank | input | 1 | Video is in vertical blanking |
| cpuClkEn | output | 1 | CPU clock enable, one tick per CPU cycle |
| memOwner | output | 2 | Current DRAM owner (0 video, 1 CPU, 2 refresh) |
| refreshReq | output | 1 | Refresh row strobe for this tick |
| refreshRow | output | ROW_W | Row to refresh when `refreshReq` is high |

## Verification
The bench goes after four kinds of corner case.

- **Selects that change mid-cycle.** A design that latched `speedSel` or `cpuIsRam` mid-cycle would produce a one-tick clock pulse, or hand a half-cycle to the wrong owner.
- **The first cycle after a mode switch.** This cycle must still follow the old mode. A design that switched at once would be out of step with the model from that tick on.
- **Blanking windows.** These include windows long enough for a complete burst (every row exactly once), windows that end mid-burst (the rest of the burst must vanish), and windows that open while full mode is active (no refresh at all).
- **The reserved select value 3.** A decoder that let value 3 fall through into full or partial mode would show the wrong cycle length.

// File: rtl/vidarb_pkg.sv
package vidarb_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL  = 2'd0,
    SPD_PARTIAL = 2'd1,
    SPD_FULL    = 2'd2
  } speedMode_t;

  typedef enum logic [1:0] {
    OWN_VIDEO   = 2'd0,
    OWN_CPU     = 2'd1,
    OWN_REFRESH = 2'd2
  } memOwner_t;

  // strobes from the cycle control to the refresh/owner datapath
  typedef struct packed {
    logic videoSlot;  // tick belongs to the video half of a cycle
    logic slotStart;  // first tick of a cycle that has a video half
    logic refreshOk;  // controller refresh permitted this cycle
  } arbStrobe_t;

  function automatic speedMode_t decodeMode(input logic [1:0] raw);
    case (raw)
      2'd1:    decodeMode = SPD_PARTIAL;
      2'd2:    decodeMode = SPD_FULL;
      default: decodeMode = SPD_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/vidarb_cycle_ctrl.sv
module vidarb_cycle_ctrl
  import vidarb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] speedSel,
  input  logic       cpuIsRam,
  output logic       cpuClkEn,
  output arbStrobe_t strb
);

  localparam int PH_W = 2;
  localparam logic [PH_W-1:0] LAST_SLOW = PH_W'(3);
  localparam logic [PH_W-1:0] LAST_FAST = PH_W'(1);
  localparam logic [PH_W-1:0] HALF      = PH_W'(2);

  logic [PH_W-1:0] phase;
  speedMode_t      curMode;
  logic            fastCyc;
  logic            cycEnd;
  speedMode_t      nextMode;
  logic            fullNow;

  assign cycEnd   = fastCyc ? (phase == LAST_FAST) : (phase == LAST_SLOW);
  assign nextMode = decodeMode(speedSel);
  assign fullNow  = (curMode == SPD_FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      curMode <= SPD_NORMAL;
      fastCyc <= 1'b0;
    end else if (cycEnd) begin
      phase   <= '0;
      curMode <= nextMode;
      fastCyc <= (nextMode == SPD_FULL) ||
                 ((nextMode == SPD_PARTIAL) && !cpuIsRam);
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  assign cpuClkEn       = cycEnd;
  assign strb.videoSlot = !fullNow && (phase < HALF);
  assign strb.slotStart = !fullNow && (phase == '0);
  assign strb.refreshOk = !fullNow;

  // R4: a clock enable is never followed directly by another
  min_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycEnd |=> !cycEnd);

  // R5: the latched mode only moves at a cycle boundary
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cycEnd |=> $stable(curMode));

endmodule

// File: rtl/vidarb_refresh_path.sv
module vidarb_refresh_path
  import vidarb_pkg::*;
#(
  parameter  int ROWS  = 128,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CNT_W = $clog2(ROWS + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             vBlank,
  input  arbStrobe_t       strb,
  output logic [1:0]       memOwner,
  output logic             refreshReq,
  output logic [ROW_W-1:0] refreshRow
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [CNT_W-1:0] BURST    = CNT_W'(ROWS);

  logic             vbPrev;
  logic [CNT_W-1:0] pending;
  logic [CNT_W-1:0] avail;
  logic [ROW_W-1:0] rowPtr;
  logic             issue;

  assign avail = (vBlank && !vbPrev) ? BURST : pending;
  assign issue = strb.slotStart && strb.refreshOk && vBlank && (avail != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vbPrev  <= 1'b0;
      pending <= '0;
      rowPtr  <= '0;
    end else begin
      vbPrev  <= vBlank;
      pending <= avail - CNT_W'(issue);
      if (issue)
        rowPtr <= (rowPtr == ROW_LAST) ? '0 : rowPtr + ROW_W'(1);
    end
  end

  always_comb begin
    if (issue)               memOwner = OWN_REFRESH;
    else if (strb.videoSlot) memOwner = OWN_VIDEO;
    else                     memOwner = OWN_CPU;
  end

  assign refreshReq = issue;
  assign refreshRow = rowPtr;

  // R9: refresh only inside blanking
  refresh_in_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |-> vBlank);

  // R7: at most one refresh per cycle
  refresh_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |=> !refreshReq);

  // R8: row pointer steps by one and wraps
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |=> (refreshRow == (($past(refreshRow) == ROW_LAST) ?
                                   '0 : $past(refreshRow) + ROW_W'(1))));

  // R10: no refresh while full speed governs the cycle
  full_norefresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.refreshOk |-> !refreshReq);

endmodule

// File: rtl/vidarb_clock_arbiter.sv
module vidarb_clock_arbiter
  import vidarb_pkg::*;
#(
  parameter  int ROWS  = 128,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       speedSel,
  input  logic             cpuIsRam,
  input  logic             vBlank,
  output logic             cpuClkEn,
  output logic [1:0]       memOwner,
  output logic             refreshReq,
  output logic [ROW_W-1:0] refreshRow
);

  arbStrobe_t strb;

  vidarb_cycle_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .speedSel (speedSel),
    .cpuIsRam (cpuIsRam),
    .cpuClkEn (cpuClkEn),
    .strb     (strb)
  );

  vidarb_refresh_path #(.ROWS(ROWS)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .vBlank     (vBlank),
    .strb       (strb),
    .memOwner   (memOwner),
    .refreshReq (refreshReq),
    .refreshRow (refreshRow)
  );

endmodule

// File: tb/vidarb_clock_arbiter_tb.sv
module vidarb_clock_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BROWS      = 8;
  localparam int BROW_W     = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        speedSel = 2'd0;
  logic              cpuIsRam = 1'b0;
  logic              vBlank = 1'b0;
  logic              cpuClkEn;
  logic [1:0]        memOwner;
  logic              refreshReq;
  logic [BROW_W-1:0] refreshRow;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidarb_clock_arbiter #(.ROWS(BROWS)) u_dut (
    .clk(clk), .rstN(rstN), .speedSel(speedSel), .cpuIsRam(cpuIsRam),
    .vBlank(vBlank), .cpuClkEn(cpuClkEn), .memOwner(memOwner),
    .refreshReq(refreshReq), .refreshRow(refreshRow)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // behavioural reference state
  int mPhase = 0, mMode = 0, mRaw = 0, mFast = 0, mPending = 0, mRow = 0, mVbPrev = 0;
  int rowHits[BROWS];
  bit r5Flag = 0;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAndStep();
    int full, isEnd, rise, avail, issue, owner, nm;
    string enTag;
    full  = (mMode == 2);
    isEnd = mFast ? (mPhase == 1) : (mPhase == 3);
    rise  = vBlank && !mVbPrev;
    avail = rise ? BROWS : mPending;
    issue = (!full && mPhase == 0 && vBlank && avail > 0);
    owner = issue ? 2 : ((!full && mPhase < 2) ? 0 : 1);
    if (r5Flag)          enTag = "R5";
    else if (mRaw == 3)  enTag = "R6";
    else if (mMode == 1) enTag = "R3";
    else if (mMode == 2) enTag = "R4";
    else                 enTag = "R2";
    chk(int'(cpuClkEn), isEnd, enTag, "cpuClkEn");
    chk(int'(memOwner), owner, "R11", "memOwner");
    chk(int'(refreshReq), issue, full ? "R10" : (vBlank ? "R7" : "R9"), "refreshReq");
    if (issue) chk(int'(refreshRow), mRow, "R8", "refreshRow");
    if (refreshReq) rowHits[int'(refreshRow)]++;
    // advance the model by one tick
    mVbPrev  = vBlank;
    mPending = avail - issue;
    if (issue) mRow = (mRow + 1) % BROWS;
    if (isEnd) begin
      mPhase = 0;
      mRaw   = int'(speedSel);
      nm     = (mRaw == 3) ? 0 : mRaw;
      mMode  = nm;
      mFast  = (nm == 2) || (nm == 1 && !cpuIsRam);
    end else begin
      mPhase++;
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic ram, input logic vb);
    speedSel = m; cpuIsRam = ram; vBlank = vb;
    #1;
    compareAndStep();
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input logic [1:0] m, input logic vb);
    for (int i = 0; i < n; i++) drive(m, 1'($urandom % 2), vb);
  endtask

  task automatic checkRows(input int exp, input string tag);
    for (int r = 0; r < BROWS; r++) begin
      chk(rowHits[r], exp, tag, "row hits per frame");
      rowHits[r] = 0;
    end
  endtask

  task automatic clearRows();
    for (int r = 0; r < BROWS; r++) rowHits[r] = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    clearRows();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(int'(cpuClkEn), 0, "R1", "cpuClkEn in reset");
    chk(int'(memOwner), 0, "R1", "memOwner in reset");
    chk(int'(refreshReq), 0, "R1", "refreshReq in reset");
    @(negedge clk);
    rstN = 1'b1;
    // R2 normal, no blanking
    ticks(40, 2'd0, 1'b0);
    // R7 R8 full burst in normal mode
    ticks(48, 2'd0, 1'b1);
    ticks(10, 2'd0, 1'b0);
    checkRows(1, "R8");
    // R3 partial mode with mixed decode, then a burst
    ticks(40, 2'd1, 1'b0);
    ticks(40, 2'd1, 1'b1);
    ticks(10, 2'd1, 1'b0);
    checkRows(1, "R8");
    // R4 R10 full mode, blanking brings no refresh
    ticks(20, 2'd2, 1'b0);
    ticks(40, 2'd2, 1'b1);
    ticks(10, 2'd2, 1'b0);
    checkRows(0, "R10");
    // R6 reserved select acts as normal, burst completes
    ticks(30, 2'd3, 1'b0);
    ticks(48, 2'd3, 1'b1);
    ticks(10, 2'd3, 1'b0);
    checkRows(1, "R6");
    // R9 short blanking truncates the burst, then a fresh full burst
    ticks(10, 2'd0, 1'b1);
    ticks(12, 2'd0, 1'b0);
    clearRows();
    ticks(48, 2'd0, 1'b1);
    ticks(10, 2'd0, 1'b0);
    checkRows(1, "R9");
    // R5 select and decode toggling every tick
    r5Flag = 1;
    for (int i = 0; i < 400; i++)
      drive(2'($urandom % 4), 1'($urandom % 2), 1'((i / 37) % 2));
    r5Flag = 0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule